// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a simple integer core. Each cycle it takes a first operand, a second operand that an upstream shifter has already shifted or rotated, and the carry bit that shifter produced. An opcode selects one of twelve operations:

- add, add with carry, subtract
- AND, OR, XOR, bit clear
- move, move-not
- compare, test, test-equivalence

The block drives the combinational result together with a strobe that says whether the operation writes a register.

A four-bit flag register holds Negative, Zero, Carry and oVerflow. It is updated on the clock edge that ends the operation. Compare and the two test operations always update it. Every other operation updates it only when its set-flags input is high. A separate four-bit condition input is checked against the flags currently held, which lets an issuing stage decide whether to execute an instruction.

Because add-with-carry reads the stored carry, a sum wider than the datapath can be built in several steps. The first step is a flag-setting add of the low words. Each later step is an add-with-carry of the next words up.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcodes 0 (add), 1 (add with carry) and 2 (subtract) drive `result` to A+B, A+B+C and A-B modulo 2^W, where C is the stored carry flag. `resultValid` is high for each of them.
- R2: Opcodes 3 (AND), 4 (OR), 5 (XOR), 6 (bit clear, A AND NOT B), 7 (move, B) and 8 (move-not, NOT B) drive the matching result with `resultValid` high. For example, bit clear of 0x02FA62CA with 0x0000FFFF gives 0x02FA0000.
- R3: Opcodes 9 (compare, A-B), 10 (test, A AND B) and 11 (test-equivalence, A XOR B) hold `resultValid` low. They update the flags at the next rising clock edge whatever the value of `setFlags`.
- R4: Opcodes 0 to 8 update the flags only when `setFlags` is high. Opcodes 12 to 15 write no result and never change the flags.
- R5: After a flag-updating add, add with carry, subtract or compare:
  - N is the top bit of the value.
  - Z is set when the value is zero.
  - C is the carry out of the adder. For subtract and compare this means C is set when no borrow occurs (A >= B unsigned).
  - V is set on two's-complement overflow.
- R6: After a flag-updating logic, move or test operation, N and Z follow the value, C takes `shiftCarry`, and V keeps its previous state.
- R7: `condPass` evaluates `condCode` against the current flags. The codes are:
  - 0 EQ (Z), 1 NE (!Z)
  - 2 CS (C), 3 CC (!C)
  - 4 MI (N), 5 PL (!N)
  - 6 VS (V), 7 VC (!V)
  - 8 HI (C & !Z), 9 LS (!C | Z)
  - 10 GE (N==V), 11 LT (N!=V)
  - 12 GT (!Z & N==V), 13 LE (Z | N!=V)
  - 14 always, 15 never
- R8: Reset (`rstN` low, asynchronous) clears the flags. The `flags` port carries them as {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R9: A flag-setting add of the low words followed by an add-with-carry of the high words yields the correct double-width sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | W | First operand |
| opB | input | W | Pre-shifted second operand |
| shiftCarry | input | 1 | Carry produced by the operand shifter |
| opcode | input | 4 | Operation select |
| setFlags | input | 1 | Request a flag update for opcodes 0 to 8 |
| condCode | input | 4 | Condition to evaluate against the flags |
| result | output | W | Operation result |
| resultValid | output | 1 | Operation writes a result |
| flags | output | 4 | Flag register {N,Z,C,V} |
| condPass | output | 1 | Condition satisfied |

## Verification
The assertions check, on every cycle:
- Compare and test never raise the result strobe.
- The flags hold when no update is requested.
- A flag-setting logic operation copies the shifter carry and keeps V.
- N and Z track any flag-setting result.
- The always, never and equal conditions read the flags correctly.

Arithmetic correctness of the result is left to the bench. So are the C and V values of adds and subtracts, the carry chain through add-with-carry, and the ordered conditions (GE, GT, HI and their complements). The bench sweeps every operand pair on a 4-bit instance and compares against an arithmetic model, then runs directed 32-bit cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_ORR = 4'd4,
    OP_EOR = 4'd5,
    OP_BIC = 4'd6,
    OP_MOV = 4'd7,
    OP_MVN = 4'd8,
    OP_CMP = 4'd9,
    OP_TST = 4'd10,
    OP_TEQ = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_PASS = 2'd3
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     isArith;
    logic     subtract;
    logic     useCarry;
    logic     complementB;
    logicFn_e logicFn;
    logic     writeResult;
    logic     touchFlags;
  } aluCtrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } aluFlags_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       setFlags,
  output aluCtrl_t   ctrl
);

  logic alwaysFlags;
  logic condFlags;

  always_comb begin
    ctrl        = '0;
    ctrl.logicFn = LF_PASS;
    alwaysFlags = 1'b0;
    condFlags   = 1'b0;
    case (opcode)
      OP_ADD: begin ctrl.isArith = 1'b1; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_ADC: begin ctrl.isArith = 1'b1; ctrl.useCarry = 1'b1; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_SUB: begin ctrl.isArith = 1'b1; ctrl.subtract = 1'b1; ctrl.complementB = 1'b1;
                    ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_AND: begin ctrl.logicFn = LF_AND; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_ORR: begin ctrl.logicFn = LF_OR;  ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_EOR: begin ctrl.logicFn = LF_XOR; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_BIC: begin ctrl.logicFn = LF_AND; ctrl.complementB = 1'b1; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_MOV: begin ctrl.logicFn = LF_PASS; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_MVN: begin ctrl.logicFn = LF_PASS; ctrl.complementB = 1'b1; ctrl.writeResult = 1'b1; condFlags = 1'b1; end
      OP_CMP: begin ctrl.isArith = 1'b1; ctrl.subtract = 1'b1; ctrl.complementB = 1'b1; alwaysFlags = 1'b1; end
      OP_TST: begin ctrl.logicFn = LF_AND; alwaysFlags = 1'b1; end
      OP_TEQ: begin ctrl.logicFn = LF_XOR; alwaysFlags = 1'b1; end
      default: ;
    endcase
    ctrl.touchFlags = alwaysFlags | (condFlags & setFlags);
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluCtrl_t     ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         shiftCarry,
  output logic [W-1:0] result,
  output aluFlags_t    flagQ
);

  localparam int MSB = W - 1;

  logic [W-1:0] bEff;
  logic         carryIn;
  logic [W:0]   adderOut;
  logic [W-1:0] logicRes;
  logic         overflow;
  aluFlags_t    flagD;

  assign bEff     = ctrl.complementB ? ~opB : opB;
  assign carryIn  = ctrl.subtract | (ctrl.useCarry & flagQ.c);
  assign adderOut = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, carryIn};
  assign overflow = (opA[MSB] == bEff[MSB]) && (adderOut[MSB] != opA[MSB]);

  always_comb begin
    case (ctrl.logicFn)
      LF_AND:  logicRes = opA & bEff;
      LF_OR:   logicRes = opA | bEff;
      LF_XOR:  logicRes = opA ^ bEff;
      default: logicRes = bEff;
    endcase
  end

  assign result = ctrl.isArith ? adderOut[W-1:0] : logicRes;

  always_comb begin
    flagD.n = result[MSB];
    flagD.z = (result == '0);
    flagD.c = ctrl.isArith ? adderOut[W] : shiftCarry;
    flagD.v = ctrl.isArith ? overflow : flagQ.v;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagQ <= '0;
    else if (ctrl.touchFlags) flagQ <= flagD;
  end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_pkg::*;
(
  input  aluFlags_t  flagQ,
  input  logic [3:0] condCode,
  output logic       condPass
);

  logic sameSign;

  assign sameSign = (flagQ.n == flagQ.v);

  always_comb begin
    case (condCode)
      4'd0:    condPass = flagQ.z;
      4'd1:    condPass = !flagQ.z;
      4'd2:    condPass = flagQ.c;
      4'd3:    condPass = !flagQ.c;
      4'd4:    condPass = flagQ.n;
      4'd5:    condPass = !flagQ.n;
      4'd6:    condPass = flagQ.v;
      4'd7:    condPass = !flagQ.v;
      4'd8:    condPass = flagQ.c && !flagQ.z;
      4'd9:    condPass = !flagQ.c || flagQ.z;
      4'd10:   condPass = sameSign;
      4'd11:   condPass = !sameSign;
      4'd12:   condPass = !flagQ.z && sameSign;
      4'd13:   condPass = flagQ.z || !sameSign;
      4'd14:   condPass = 1'b1;
      default: condPass = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         shiftCarry,
  input  logic [3:0]   opcode,
  input  logic         setFlags,
  input  logic [3:0]   condCode,
  output logic [W-1:0] result,
  output logic         resultValid,
  output logic [3:0]   flags,
  output logic         condPass
);

  aluCtrl_t  ctrl;
  aluFlags_t flagQ;

  alu_control uCtrl (
    .opcode   (opcode),
    .setFlags (setFlags),
    .ctrl     (ctrl)
  );

  alu_datapath #(.W(W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .result     (result),
    .flagQ      (flagQ)
  );

  alu_cond_eval uCond (
    .flagQ    (flagQ),
    .condCode (condCode),
    .condPass (condPass)
  );

  assign resultValid = ctrl.writeResult;
  assign flags       = flagQ;

endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   opcode,
  input logic         setFlags,
  input logic         shiftCarry,
  input logic [3:0]   condCode,
  input logic [W-1:0] result,
  input logic         resultValid,
  input logic [3:0]   flags,
  input logic         condPass
);

  logic compareOp;
  logic logicOp;

  assign compareOp = (opcode == OP_CMP) || (opcode == OP_TST) || (opcode == OP_TEQ);
  assign logicOp   = (opcode >= OP_AND) && (opcode <= OP_MVN);

  assert_compare_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    compareOp |-> !resultValid);

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!compareOp && !setFlags) |=> $stable(flags));

  assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (logicOp && setFlags) |=> (flags[1] == $past(shiftCarry)) && (flags[0] == $past(flags[0])));

  assert_nz_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && setFlags) |=> (flags[2] == ($past(result) == '0)) && (flags[3] == $past(result[W-1])));

  assert_cond_always_R7: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'd14) |-> condPass);

  assert_cond_never_R7: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'd15) |-> !condPass);

  assert_cond_equal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'd0) |-> (condPass == flags[2]));

endmodule

bind alu_flags_unit alu_flags_checker #(.W(W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .opcode      (opcode),
  .setFlags    (setFlags),
  .shiftCarry  (shiftCarry),
  .condCode    (condCode),
  .result      (result),
  .resultValid (resultValid),
  .flags       (flags),
  .condPass    (condPass)
);

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/1ps
module sim_alu_flags_unit;

  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // small instance for sweeps
  logic [SW-1:0] a0, b0, res0;
  logic sc0, sf0, rv0, cp0;
  logic [3:0] op0, cc0, fl0;

  // full-width instance for directed cases
  logic [31:0] a1, b1, res1;
  logic sc1, sf1, rv1, cp1;
  logic [3:0] op1, cc1, fl1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_flags_unit #(.W(SW)) u0 (
    .clk(clk), .rstN(rstN), .opA(a0), .opB(b0), .shiftCarry(sc0), .opcode(op0),
    .setFlags(sf0), .condCode(cc0), .result(res0), .resultValid(rv0), .flags(fl0), .condPass(cp0));

  alu_flags_unit #(.W(32)) u1 (
    .clk(clk), .rstN(rstN), .opA(a1), .opB(b1), .shiftCarry(sc1), .opcode(op1),
    .setFlags(sf1), .condCode(cc1), .result(res1), .resultValid(rv1), .flags(fl1), .condPass(cp1));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit condExp(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;        4'd1: return !z;
      4'd2: return c;        4'd3: return !c;
      4'd4: return n;        4'd5: return !n;
      4'd6: return v;        4'd7: return !v;
      4'd8: return c && !z;  4'd9: return !c || z;
      4'd10: return n == v;  4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic [3:0] modelFlags = 4'b0000;

  task automatic step(input int op, input int a, input int b, input bit sc, input bit sf, input int cc);
    int mask, bv, cin, s, r, msb;
    bit arith, valid, touch, cOut, vOut;
    string tag;
    mask = (1 << SW) - 1;
    msb = SW - 1;
    a0 = a[SW-1:0]; b0 = b[SW-1:0]; sc0 = sc; sf0 = sf; op0 = op[3:0]; cc0 = cc[3:0];
    arith = 1'b0; valid = (op <= 8); r = 0; cOut = sc; vOut = modelFlags[0];
    case (op)
      0, 1, 2, 9: begin
        arith = 1'b1;
        bv = (op == 2 || op == 9) ? (~b & mask) : b;
        cin = (op == 2 || op == 9) ? 1 : (op == 1 ? int'(modelFlags[1]) : 0);
        s = a + bv + cin;
        r = s & mask;
        cOut = s[SW];
        vOut = (a[msb] == bv[msb]) && (r[msb] != a[msb]);
      end
      3, 10: r = a & b;
      4: r = a | b;
      5, 11: r = a ^ b;
      6: r = a & ~b & mask;
      7: r = b;
      8: r = ~b & mask;
      default: r = 0;
    endcase
    touch = (op >= 9 && op <= 11) || (op <= 8 && sf);
    tag = arith ? "R1/R5" : "R2/R6";
    #1;
    // flags from previous steps and condition on them
    chk(fl0 == modelFlags, (op >= 12) ? "R4 flags" : "R4/R5/R6 flags", fl0, modelFlags);
    chk(cp0 == condExp(cc[3:0], modelFlags), "R7 cond", cp0, condExp(cc[3:0], modelFlags));
    chk(rv0 == valid, (op >= 9) ? "R3/R4 valid" : "R1/R2 valid", rv0, valid);
    if (valid) chk(int'(res0) == r, tag, res0, r);
    if (touch) begin
      modelFlags = {r[msb], (r == 0), cOut, vOut};
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive1(input int op, input logic [31:0] a, input logic [31:0] b, input bit sf, input int cc);
    a1 = a; b1 = b; op1 = op[3:0]; sf1 = sf; cc1 = cc[3:0]; sc1 = 1'b0;
    #1;
  endtask

  initial begin
    a0 = '0; b0 = '0; sc0 = 0; sf0 = 0; op0 = 4'd15; cc0 = '0;
    a1 = '0; b1 = '0; sc1 = 0; sf1 = 0; op1 = 4'd15; cc1 = '0;
    repeat (3) @(negedge clk);
    // R8: flags cleared by reset
    chk(fl0 == 4'b0000, "R8 reset small", fl0, 0);
    chk(fl1 == 4'b0000, "R8 reset wide", fl1, 0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep over all operand pairs, every opcode, both setFlags values
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int sf = 0; sf < 2; sf++)
            step(op, a, b, bit'((a ^ b ^ sf) & 1), bit'(sf), (a + b + op + sf) % 16);
    // ADC with both carry states after SUB-set flags
    step(2, 5, 3, 1'b0, 1'b1, 2);   // C=1 (no borrow)
    step(1, 4, 4, 1'b0, 1'b0, 2);   // R1 ADC uses C=1 -> 9
    step(2, 3, 5, 1'b0, 1'b1, 3);   // C=0
    step(1, 4, 4, 1'b0, 1'b0, 3);   // R1 ADC uses C=0 -> 8
    step(15, 0, 0, 1'b0, 1'b1, 14); // R4 undefined opcode
    #1;
    chk(fl0 == modelFlags, "R4 final flags", fl0, modelFlags);

    // R2 bit clear example on full width
    drive1(6, 32'h02FA62CA, 32'h0000FFFF, 1'b0, 14);
    chk(res1 == 32'h02FA0000, "R2 bit clear", res1, 32'h02FA0000);
    @(posedge clk); @(negedge clk);
    // R9 double-width add: 0x00000001_FFFFFFFF + 0x00000002_00000001
    drive1(0, 32'hFFFFFFFF, 32'h00000001, 1'b1, 2);
    chk(res1 == 32'h0, "R9 low word", res1, 0);
    @(posedge clk); @(negedge clk);
    #1;
    chk(fl1 == 4'b0110, "R9/R5 low flags", fl1, 4'b0110);
    drive1(1, 32'h00000001, 32'h00000002, 1'b0, 2);
    chk(cp1 == 1'b1, "R7 carry set", cp1, 1);
    chk(res1 == 32'h00000004, "R9 high word", res1, 4);
    @(posedge clk); @(negedge clk);
    // R5 signed overflow at full width
    drive1(0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 6);
    @(posedge clk); @(negedge clk);
    #1;
    chk(fl1 == 4'b1001, "R5 overflow flags", fl1, 4'b1001);
    // R3 compare equal, flags set without setFlags
    drive1(9, 32'h12345678, 32'h12345678, 1'b0, 0);
    chk(rv1 == 1'b0, "R3 compare valid", rv1, 0);
    @(posedge clk); @(negedge clk);
    #1;
    chk(fl1 == 4'b0110, "R3 compare flags", fl1, 4'b0110);
    chk(cp1 == 1'b1, "R7 equal", cp1, 1);
    drive1(15, 0, 0, 1'b0, 12);
    chk(cp1 == 1'b0, "R7 greater false on equal", cp1, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule